// File: doc/BRIEF.md
# Clear-on-Read Error Counter Bank

This block sits beside the receive path of a telecom framer and keeps two performance-monitor error tallies for a host processor. One is a narrow tally of frame check sequence errors that a link-layer (HDLC-style) controller reports. The other is a wide tally of pseudo-random bit sequence errors. Each detector delivers a one-cycle event pulse for every error. The matching counter adds one per pulse and stops at its all-ones value instead of wrapping.

The host reads the counters through an 8-bit read port. The port has a strobe and a byte offset. Each counter clears when it is read, so every value the host sees is the number of events since the previous read of that counter. The wide counter spans two byte offsets. The host reads the upper byte first. That read takes a snapshot of the whole count into a holding register and restarts the live counter. The lower-byte read that follows returns the low half of the snapshot. The pair therefore gives a coherent value, and events that arrive between the two reads go into the next accumulation.

Read data is registered. It appears on the clock edge that ends the first cycle of a strobe and stays put until the next access.

Top module: `pmon_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, both counters, the holding register and the read data are zero, and every mapped offset reads 0x00.
- R2: Each cycle with the frame-check error event high adds one to the 8-bit counter. A read at offset 0x0C returns the count and clears it, so an immediate second read returns 0x00.
- R3: Neither counter wraps. The 8-bit counter stays at 0xFF and the 16-bit counter stays at 0xFFFF under further events, and the read returns those values.
- R4: If an event arrives in the same cycle as the read that clears its counter, the read returns the count from before that event and the counter restarts at 1.
- R5: A read at offset 0x0D returns bits 15:8 of the 16-bit counter. It copies all 16 bits into the holding register and clears the live counter.
- R6: The first read at offset 0x0E after a 0x0D read returns bits 7:0 of the held snapshot and releases the hold.
- R7: A read at offset 0x0E with no pending hold returns bits 7:0 of the live 16-bit counter and does not clear it.
- R8: A read strobe held high for several cycles is one access. The read data updates only on the edge that ends its first cycle, clearing happens only on that edge, and events during the rest of the strobe are counted.
- R9: Reads at any offset other than 0x0C, 0x0D and 0x0E return 0x00. They leave both counters and any pending hold unchanged.
- R10: Events that arrive between a 0x0D read and the following 0x0E read do not change the value returned by the 0x0E read. They appear in the next 0x0D/0x0E pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcs_err_evt | input | 1 | One pulse per frame check sequence error |
| prbs_err_evt | input | 1 | One pulse per pseudo-random sequence bit error |
| rd_en | input | 1 | Host read strobe; its rising edge starts one access |
| rd_addr | input | 8 | Byte offset of the access |
| rd_data | output | 8 | Registered read data |

## Verification
The bench targets the read edges where a counter can lose or double-count events.

- **Event on the clearing edge.** An event lands exactly on the clearing edge. A design that cleared to zero would return 0 on the next read instead of 1.
- **Events between the two halves.** Events arrive between the upper and lower reads. A design without a snapshot would return a low byte that mixes in those events, or would drop them from the next pair.
- **Lower byte read alone.** The lower byte is read on its own, twice. A design that cleared on that path would return zero the second time.
- **Long strobe.** A long strobe with events under it would expose repeated clearing, because the counts would come back too small.
- **Saturation.** Saturation is driven past 0xFF and 0xFFFF. A wrapping counter would return a small value.
- **Unmapped read during a hold.** An unmapped read placed between the two halves of a pair would show any unintended release of the hold.

// File: rtl/pmon_pkg.sv
// Shared definitions for the clear-on-read error counter bank.
// Assumes a byte-wide host read port.
package pmon_pkg;
    localparam int BYTE_W = 8;

    // Which counter register an access targets
    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_FCS     = 2'd1,
        SEL_WIDE_HI = 2'd2,
        SEL_WIDE_LO = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pmon_sat_counter.sv
// Saturating event counter with synchronous clear.
// A clear in the same cycle as an increment leaves the counter at 1, so
// that event is kept. Assumes inc and clr are single-cycle qualified.
module pmon_sat_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic at_max;
    assign at_max = &count;

    // Count events, clear on request, hold at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? ONE : '0;
        end else if (inc && !at_max) begin
            count <= count + ONE;
        end
    end

    // R3: a full counter stays full under further events
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && inc && !clr) |=> (&count));

    // R4: an event on the clearing edge restarts the count at one
    a_r4_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (count == ONE));

    // R2: a clear with no event empties the counter
    a_r2_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (count == '0));

    // R2: with no event and no clear the count holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/pmon_access_decode.sv
// Turns the host read strobe into a single-cycle access pulse and maps
// the byte offset to a register select. A strobe held for many cycles
// yields one pulse. Assumes rd_addr is stable while rd_en is high.
module pmon_access_decode
    import pmon_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_FCS = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_HI  = 8'h0D,
    parameter logic [ADDR_W-1:0] OFS_LO  = 8'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              access,
    output reg_sel_e          sel
);
    logic rd_en_q;

    // Remember the strobe level to find its first cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rd_en_q <= 1'b0;
        else        rd_en_q <= rd_en;
    end

    assign access = rd_en && !rd_en_q;

    // Map the offset to a register select
    always_comb begin
        if      (rd_addr == OFS_FCS) sel = SEL_FCS;
        else if (rd_addr == OFS_HI)  sel = SEL_WIDE_HI;
        else if (rd_addr == OFS_LO)  sel = SEL_WIDE_LO;
        else                         sel = SEL_NONE;
    end

    // R8: a strobe never yields access pulses on two cycles in a row
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !access);
endmodule

// File: rtl/pmon_counter_bank.sv
// Clear-on-read performance counter bank: a narrow frame-check error
// counter and a wide bit-error counter behind a byte read port. The wide
// counter is read upper byte first. That read snapshots and clears it,
// and the following lower-byte read returns the snapshot. Assumes event
// inputs are synchronous single-cycle pulses.
module pmon_counter_bank
    import pmon_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                FCS_W   = 8,
    parameter int                WIDE_W  = 16,
    parameter logic [ADDR_W-1:0] OFS_FCS = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_HI  = 8'h0D,
    parameter logic [ADDR_W-1:0] OFS_LO  = 8'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcs_err_evt,
    input  logic              prbs_err_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int HI_LSB = WIDE_W - BYTE_W;

    logic              access;
    reg_sel_e          sel;
    logic [FCS_W-1:0]  fcs_cnt;
    logic [WIDE_W-1:0] wide_cnt;
    logic [WIDE_W-1:0] hold_q;
    logic              hold_vld;
    logic [BYTE_W-1:0] fcs_byte;
    logic              clr_fcs;
    logic              clr_wide;

    pmon_access_decode #(
        .ADDR_W (ADDR_W),
        .OFS_FCS(OFS_FCS),
        .OFS_HI (OFS_HI),
        .OFS_LO (OFS_LO)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .access (access),
        .sel    (sel)
    );

    assign clr_fcs  = access && (sel == SEL_FCS);
    assign clr_wide = access && (sel == SEL_WIDE_HI);

    pmon_sat_counter #(.WIDTH(FCS_W)) u_fcs_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (fcs_err_evt),
        .clr  (clr_fcs),
        .count(fcs_cnt)
    );

    pmon_sat_counter #(.WIDTH(WIDE_W)) u_wide_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (prbs_err_evt),
        .clr  (clr_wide),
        .count(wide_cnt)
    );

    // Zero-extend the narrow counter to a byte
    always_comb begin
        fcs_byte = '0;
        fcs_byte[FCS_W-1:0] = fcs_cnt;
    end

    // Register read data and manage the upper/lower snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else if (access) begin
            case (sel)
                SEL_FCS: rd_data <= fcs_byte;
                SEL_WIDE_HI: begin
                    rd_data  <= wide_cnt[WIDE_W-1:HI_LSB];
                    hold_q   <= wide_cnt;
                    hold_vld <= 1'b1;
                end
                SEL_WIDE_LO: begin
                    rd_data  <= hold_vld ? hold_q[BYTE_W-1:0] : wide_cnt[BYTE_W-1:0];
                    hold_vld <= 1'b0;
                end
                default: rd_data <= '0;
            endcase
        end
    end

    // R5: an upper read snapshots the live count from before its edge
    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (access && sel == SEL_WIDE_HI) |=> (hold_vld && hold_q == $past(wide_cnt)));

    // R6: a lower read always releases the hold
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (access && sel == SEL_WIDE_LO) |=> !hold_vld);

    // R8: read data changes only on the first cycle of a strobe
    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(rd_data));

    // R9: unmapped reads return zero and keep the hold
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (access && sel == SEL_NONE) |=> (rd_data == '0 && $stable(hold_vld)));
endmodule

// File: tb/pmon_counter_bank_test.sv
// Scoreboard bench: the driver queues expected read bytes, and a monitor
// pops and compares them on the cycle after each access.
`timescale 1ns/1ps
module pmon_counter_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcs_err_evt = 1'b0;
    logic       prbs_err_evt = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    logic      rd_prev = 1'b0;
    logic      pend = 1'b0;

    always #2.5 clk = ~clk;

    pmon_counter_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fcs_err_evt (fcs_err_evt),
        .prbs_err_evt(prbs_err_evt),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // Track which edges start an access
    always @(posedge clk) begin
        pend    <= rd_en && !rd_prev;
        rd_prev <= rd_en;
    end

    // Monitor: compare read data against the queued expectation
    always @(negedge clk) begin
        if (pend) begin
            if (sb_q.size() == 0) begin
                check("SB unexpected access", rd_data, 8'hxx);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic events(input bit fcs, input int n);
        if (n > 0) begin
            if (fcs) fcs_err_evt = 1'b1; else prbs_err_evt = 1'b1;
            repeat (n) @(negedge clk);
            fcs_err_evt  = 1'b0;
            prbs_err_evt = 1'b0;
        end
    endtask

    // Driver: one access, optional frame-check events under the strobe
    task automatic rd_access(input logic [7:0] a, input logic [7:0] e, input string tag,
                             input int hold_cyc, input bit evt_first, input bit evt_rest);
        exp_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_addr = a;
        rd_en   = 1'b1;
        for (int i = 0; i < hold_cyc; i++) begin
            fcs_err_evt = (i == 0) ? evt_first : evt_rest;
            @(negedge clk);
            if (i > 0) check({tag, " held strobe"}, rd_data, e);
        end
        rd_en       = 1'b0;
        fcs_err_evt = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        rd_access(a, e, tag, 1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h0C, 8'h00, "R1 fcs");
        rd(8'h0D, 8'h00, "R1 wide hi");
        rd(8'h0E, 8'h00, "R1 wide lo");

        events(1, 5);
        rd(8'h0C, 8'h05, "R2 count");
        rd(8'h0C, 8'h00, "R2 cleared");

        events(0, 300);
        rd(8'h0D, 8'h01, "R5 upper");
        rd(8'h0E, 8'h2C, "R6 held lower");
        rd(8'h0E, 8'h00, "R7 live after clear");

        events(0, 7);
        rd(8'h0E, 8'h07, "R7 live lower");
        rd(8'h0E, 8'h07, "R7 no clear");
        rd(8'h0D, 8'h00, "R5 upper small");
        rd(8'h0E, 8'h07, "R6 held small");

        events(0, 3);
        rd(8'h0D, 8'h00, "R10 upper");
        events(0, 2);
        rd(8'h0E, 8'h03, "R10 snapshot");
        rd(8'h0D, 8'h00, "R10 next upper");
        rd(8'h0E, 8'h02, "R10 next lower");

        events(1, 4);
        rd_access(8'h0C, 8'h04, "R4 read on event", 1, 1'b1, 1'b0);
        rd(8'h0C, 8'h01, "R4 restart at one");

        events(1, 3);
        rd_access(8'h0C, 8'h03, "R8 long strobe", 5, 1'b0, 1'b1);
        rd(8'h0C, 8'h04, "R8 events under strobe");

        events(1, 6);
        rd(8'h00, 8'h00, "R9 offset 0x00");
        rd(8'h0F, 8'h00, "R9 offset 0x0F");
        rd(8'h0C, 8'h06, "R9 fcs untouched");
        events(0, 261);
        rd(8'h0D, 8'h01, "R9 upper");
        rd(8'h40, 8'h00, "R9 offset 0x40");
        rd(8'h0E, 8'h05, "R9 hold kept");

        events(1, 300);
        rd(8'h0C, 8'hFF, "R3 fcs saturate");
        rd(8'h0C, 8'h00, "R3 fcs cleared");
        events(0, 65600);
        rd(8'h0D, 8'hFF, "R3 wide upper");
        rd(8'h0E, 8'hFF, "R3 wide lower");
        rd(8'h0D, 8'h00, "R3 wide cleared");

        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL SB drain: actual=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule